// File: doc/BRIEF.md
# Interleaved Radix-4 Ripple Significand Adder

This block adds two significand-width operands plus a carry-in and returns the sum and the carry-out. It does not use a fixed-latency tree adder. Instead it holds several small ripple units, each of which moves carries forward by one 2-bit (radix-4) digit per clock. A unit reports completion as soon as no digit is still waiting on an incoming carry, so short carry chains, which are the usual case, finish in a few cycles and long ones take longer.

A rotating issue stage hands each accepted operation to the next unit in turn. A rotating retire stage collects results in that same order, so the output stream keeps the issue order even when a later operation settles first. Both edges use valid/ready handshakes. Because several units are in flight at once, the variable per-operation latency is hidden from throughput whenever chains are short.

The `INC_MODE` parameter turns the block into an incrementer: the second operand is forced to zero and the result is the first operand plus the carry-in. In that configuration two units are the intended count.

Top module: `r4_interleaved_adder`

## Requirements
- R1: When a result is presented, `out_sum_o` equals the low WIDTH bits of in_a + in_b + in_cin for the operation being returned (in_b taken as zero when INC_MODE is 1).
- R2: `out_cout_o` is bit WIDTH of that same sum, the carry out of the most significant digit.
- R3: Digit d holds bits 2d+1:2d. Let L be the longest run of consecutive digits, among digits 1 and above, whose two operand digits add to exactly 3. Counting the accepting clock edge as the first, the result is presented after exactly L+1 rising edges.
- R4: With operations accepted but not yet returned numbering n, `in_ready_o` is high exactly when n is below NUM_UNITS; further operations wait while the unit next in rotation is occupied.
- R5: Results leave in acceptance order; a later result is never presented while an earlier one is still resolving, and `out_valid_o` is low when nothing is outstanding.
- R6: While `out_valid_o` is high and `out_ready_i` low, `out_valid_o`, `out_sum_o` and `out_cout_o` stay unchanged into the next cycle.
- R7: During and right after reset, `in_ready_o` is high and `out_valid_o` is low.
- R8: With INC_MODE set to 1, `in_b_i` is ignored: the result is in_a + in_cin, and the latency follows R3 with operand b taken as zero.
- R9: A result may be returned in the same cycle another operation is accepted; a stream with no propagate digits and `out_ready_i` held high is accepted at one operation per cycle without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be accepted this cycle |
| in_a_i | input | WIDTH | First operand |
| in_b_i | input | WIDTH | Second operand (ignored when INC_MODE is 1) |
| in_cin_i | input | 1 | Carry into digit 0 |
| out_valid_o | output | 1 | Result presented |
| out_ready_i | input | 1 | Consumer takes the result |
| out_sum_o | output | WIDTH | Sum bits |
| out_cout_o | output | 1 | Carry out of the top digit |

## Verification
The two functions that collide are acceptance of a new operation by one unit and retirement of a finished result from another unit in the same clock; a third overlap is a unit that finishes out of turn while an earlier unit is still resolving. The first is provoked by streaming short-chain operations with the consumer always ready, then by random valid and ready patterns, and judged by a per-clock occupancy model predicting `in_ready_o` and by a count of cycles in which both handshakes fire. The second is provoked by issuing a 27-digit chain followed by a zero-chain operation with the consumer stalled, and judged by `out_valid_o` staying low until the long one settles and by the queue model checking each returned sum in issue order.

// File: rtl/r4_adder_pkg.sv
`timescale 1ns/1ps
package r4_adder_pkg;

  typedef enum logic [1:0] {
    DIG_KILL = 2'd0,
    DIG_PROP = 2'd1,
    DIG_GEN  = 2'd2
  } dig_kind_e;

  // classify a radix-4 digit by the sum of its two operand digits
  function automatic dig_kind_e dig_classify(input logic [2:0] s);
    if (s >= 3'd4) return DIG_GEN;
    if (s == 3'd3) return DIG_PROP;
    return DIG_KILL;
  endfunction

endpackage

// File: rtl/r4_ripple_unit.sv
`timescale 1ns/1ps
module r4_ripple_unit
  import r4_adder_pkg::*;
#(
  parameter int WIDTH    = 56,
  parameter int INC_MODE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             release_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int DIGITS = WIDTH / 2;

  logic [WIDTH-1:0]  b_eff, a_q, b_q;
  logic              cin_q, busy_q;
  logic [DIGITS-1:0] co_q, pend_q, co_ld, pend_ld, co_nx, pend_nx;

  assign b_eff = (INC_MODE != 0) ? '0 : b_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic [2:0] s_ld;
    dig_kind_e  kind;
    logic       c_in;

    assign s_ld = {1'b0, a_i[2*d +: 2]} + {1'b0, b_eff[2*d +: 2]};
    assign kind = dig_classify(s_ld);

    if (d == 0) begin : g_lsd
      // carry-in is known at load, so digit 0 never waits
      assign co_ld[d]   = (kind == DIG_GEN) | ((kind == DIG_PROP) & cin_i);
      assign pend_ld[d] = 1'b0;
      assign co_nx[d]   = co_q[d];
      assign pend_nx[d] = 1'b0;
      assign c_in       = cin_q;
    end else begin : g_hsd
      assign co_ld[d]   = (kind == DIG_GEN);
      assign pend_ld[d] = (kind == DIG_PROP);
      // a waiting digit settles once the digit below has settled
      assign pend_nx[d] = pend_q[d] & pend_q[d-1];
      assign co_nx[d]   = (pend_q[d] & ~pend_q[d-1]) ? co_q[d-1] : co_q[d];
      assign c_in       = co_q[d-1];
    end

    assign sum_o[2*d +: 2] = a_q[2*d +: 2] + b_q[2*d +: 2] + {1'b0, c_in};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      cin_q  <= 1'b0;
      co_q   <= '0;
      pend_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      a_q    <= a_i;
      b_q    <= b_eff;
      cin_q  <= cin_i;
      co_q   <= co_ld;
      pend_q <= pend_ld;
    end else begin
      if (release_i) busy_q <= 1'b0;
      co_q   <= co_nx;
      pend_q <= pend_nx;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q & ~|pend_q;
  assign cout_o = co_q[DIGITS-1];

  p_sum_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({cout_o, sum_o} == ({1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q})));

  p_progress_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (|pend_q) && !load_i) |=> ($countones(pend_q) < $past($countones(pend_q))));

  p_load_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);

  p_release_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> done_o);

  p_done_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !release_i) |=> (done_o && $stable(sum_o) && $stable(cout_o)));

endmodule

// File: rtl/r4_issue_rotor.sv
`timescale 1ns/1ps
module r4_issue_rotor #(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [NUM_UNITS-1:0] busy_i,
  output logic                 ready_o,
  output logic [NUM_UNITS-1:0] load_o
);

  localparam int PTRW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam logic [PTRW-1:0] PTR_LAST = PTRW'(NUM_UNITS - 1);

  logic [PTRW-1:0] ptr_q;
  logic            fire;

  assign ready_o = ~busy_i[ptr_q];
  assign fire    = valid_i & ready_o;

  always_comb begin
    load_o        = '0;
    load_o[ptr_q] = fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (fire) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  p_rotate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && ptr_q != PTR_LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && busy_i[ptr_q]) |=> $stable(ptr_q));

endmodule

// File: rtl/r4_retire_rotor.sv
`timescale 1ns/1ps
module r4_retire_rotor #(
  parameter int NUM_UNITS = 4,
  parameter int PTRW      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_UNITS-1:0] done_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [NUM_UNITS-1:0] release_o,
  output logic [PTRW-1:0]      sel_o
);

  localparam logic [PTRW-1:0] PTR_LAST = PTRW'(NUM_UNITS - 1);

  logic [PTRW-1:0] ptr_q;
  logic            take;

  // only the head of the rotation may be presented
  assign valid_o = done_i[ptr_q];
  assign take    = valid_o & ready_i;
  assign sel_o   = ptr_q;

  always_comb begin
    release_o        = '0;
    release_o[ptr_q] = take;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (take) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  p_head_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i[ptr_q] |=> $stable(ptr_q));

  p_head_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(sel_o)));

endmodule

// File: rtl/r4_interleaved_adder.sv
`timescale 1ns/1ps
module r4_interleaved_adder #(
  parameter int WIDTH     = 56,
  parameter int NUM_UNITS = 4,
  parameter int INC_MODE  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] in_a_i,
  input  logic [WIDTH-1:0] in_b_i,
  input  logic             in_cin_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [WIDTH-1:0] out_sum_o,
  output logic             out_cout_o
);

  localparam int PTRW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

  logic [NUM_UNITS-1:0] unit_busy, unit_done, unit_load, unit_rel, unit_cout;
  logic [WIDTH-1:0]     unit_sum [NUM_UNITS];
  logic [PTRW-1:0]      sel;

  r4_issue_rotor #(.NUM_UNITS(NUM_UNITS)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .busy_i  (unit_busy),
    .ready_o (in_ready_o),
    .load_o  (unit_load)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    r4_ripple_unit #(.WIDTH(WIDTH), .INC_MODE(INC_MODE)) u_ripple (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (unit_load[u]),
      .a_i       (in_a_i),
      .b_i       (in_b_i),
      .cin_i     (in_cin_i),
      .release_i (unit_rel[u]),
      .busy_o    (unit_busy[u]),
      .done_o    (unit_done[u]),
      .sum_o     (unit_sum[u]),
      .cout_o    (unit_cout[u])
    );
  end

  r4_retire_rotor #(.NUM_UNITS(NUM_UNITS), .PTRW(PTRW)) u_retire (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (unit_done),
    .ready_i   (out_ready_i),
    .valid_o   (out_valid_o),
    .release_o (unit_rel),
    .sel_o     (sel)
  );

  assign out_sum_o  = unit_sum[sel];
  assign out_cout_o = unit_cout[sel];

  p_full_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&unit_busy) |-> !in_ready_o);

  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_sum_o) && $stable(out_cout_o)));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~|unit_busy) |-> (in_ready_o && !out_valid_o));

endmodule

// File: tb/r4_interleaved_adder_bench.sv
`timescale 1ns/1ps
module r4_interleaved_adder_bench;

  localparam int W = 56;
  localparam int N = 4;
  localparam int D = W / 2;
  localparam logic [W-1:0] PAT_5 = {(W/2){2'b01}};
  localparam logic [W-1:0] PAT_A = {(W/2){2'b10}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic         in_valid = 1'b0, in_cin = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         in_ready, out_valid, out_cout;
  logic [W-1:0] out_sum;

  logic         i_in_valid = 1'b0, i_in_cin = 1'b0;
  logic [W-1:0] i_in_a = '0, i_in_b = '0;
  logic         i_in_ready, i_out_valid, i_out_cout;
  logic [W-1:0] i_out_sum;

  r4_interleaved_adder #(.WIDTH(W), .NUM_UNITS(N), .INC_MODE(0)) u_r4_interleaved_adder (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_a_i(in_a), .in_b_i(in_b), .in_cin_i(in_cin), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_sum_o(out_sum), .out_cout_o(out_cout));

  r4_interleaved_adder #(.WIDTH(W), .NUM_UNITS(2), .INC_MODE(1)) u_r4_interleaved_adder_inc (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(i_in_valid), .in_ready_o(i_in_ready),
    .in_a_i(i_in_a), .in_b_i(i_in_b), .in_cin_i(i_in_cin), .out_valid_o(i_out_valid),
    .out_ready_i(1'b1), .out_sum_o(i_out_sum), .out_cout_o(i_out_cout));

  int checks = 0, errors = 0, count = 0, both_cnt = 0, stalls = 0;
  logic [W:0] exp_q[$];
  logic       prev_hold = 1'b0;
  logic [W:0] prev_val = '0;
  bit         rnd_ready = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_w();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[W-1:0];
  endfunction

  function automatic int chain(input logic [W-1:0] a, input logic [W-1:0] b);
    int run = 0, best = 0;
    for (int d = 1; d < D; d++) begin
      if (int'(a[2*d +: 2]) + int'(b[2*d +: 2]) == 3) begin
        run++;
        if (run > best) best = run;
      end else run = 0;
    end
    return best;
  endfunction

  // per-clock reference: occupancy count and in-order queue of expected results
  always @(negedge clk) begin
    #4;
    if (rst_ni) begin
      chk(in_ready == (count < N), "R4 ready vs occupancy", 64'(in_ready), 64'(count < N));
      if (count == 0) chk(!out_valid, "R5 idle output", 64'(out_valid), 64'd0);
      if (prev_hold)
        chk(out_valid && {out_cout, out_sum} == prev_val, "R6 stalled hold",
            64'({out_cout, out_sum}), 64'(prev_val));
      if (out_valid) begin
        chk(exp_q.size() > 0, "R5 result without operation", 64'(exp_q.size()), 64'd1);
        if (exp_q.size() > 0) begin
          chk(out_sum == exp_q[0][W-1:0], "R1 R5 sum in order", 64'(out_sum), 64'(exp_q[0][W-1:0]));
          chk(out_cout == exp_q[0][W], "R2 carry-out", 64'(out_cout), 64'(exp_q[0][W]));
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_val  = {out_cout, out_sum};
      if (in_valid && in_ready) begin
        exp_q.push_back({1'b0, in_a} + {1'b0, in_b} + {{W{1'b0}}, in_cin});
        count++;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        count--;
      end
      if (in_valid && in_ready && out_valid && out_ready) both_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rnd_ready) begin
      #1;
      out_ready = 1'($urandom_range(0, 1));
    end
  end

  // called at negedge+1, returns at negedge+1 after acceptance
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    bit acc;
    in_valid = 1'b1; in_a = a; in_b = b; in_cin = c;
    do begin
      #3;
      acc = in_ready;
      @(negedge clk); #1;
      if (!acc) stalls++;
    end while (!acc);
  endtask

  task automatic wait_empty();
    int guard = 0;
    while (count != 0 && guard < 500) begin
      @(negedge clk); #1;
      guard++;
    end
  endtask

  task automatic lat_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    int lat, want;
    want = chain(a, b) + 1;
    wait_empty();
    send(a, b, c);
    in_valid = 1'b0;
    #3;
    lat = 1;
    while (!out_valid && lat < 100) begin
      @(negedge clk); #4;
      lat++;
    end
    chk(lat == want, "R3 latency", 64'(lat), 64'(want));
    @(negedge clk); #1;
  endtask

  task automatic inc_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    int lat, want;
    logic [W:0] exp;
    want = chain(a, '0) + 1;
    exp  = {1'b0, a} + {{W{1'b0}}, c};
    i_in_valid = 1'b1; i_in_a = a; i_in_b = b; i_in_cin = c;
    #3;
    chk(i_in_ready, "R8 incrementer ready", 64'(i_in_ready), 64'd1);
    @(negedge clk); #1;
    i_in_valid = 1'b0;
    #3;
    lat = 1;
    while (!i_out_valid && lat < 100) begin
      @(negedge clk); #4;
      lat++;
    end
    chk(i_out_sum == exp[W-1:0], "R8 increment sum ignores b", 64'(i_out_sum), 64'(exp[W-1:0]));
    chk(i_out_cout == exp[W], "R8 increment carry-out", 64'(i_out_cout), 64'(exp[W]));
    chk(lat == want, "R8 increment latency", 64'(lat), 64'(want));
    @(negedge clk); #1;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    repeat (3) @(negedge clk);
    #4;
    chk(in_ready == 1'b1, "R7 reset ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R7 reset output", 64'(out_valid), 64'd0);
    chk(i_out_valid == 1'b0, "R7 reset incrementer output", 64'(i_out_valid), 64'd0);
    @(negedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk); #4;
    chk(in_ready && !out_valid, "R7 after reset", 64'({in_ready, out_valid}), 64'b10);
    @(negedge clk); #1;

    // R3 latency against chain length, results checked by the monitor (R1, R2)
    out_ready = 1'b1;
    lat_op('0, '0, 1'b0);
    lat_op(PAT_5, PAT_A, 1'b1);
    lat_op(W'(56'h3FF), '0, 1'b1);
    lat_op({W{1'b1}}, '0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      ra = rnd_w();
      lat_op(ra, rnd_w(), 1'($urandom_range(0, 1)));
    end

    // R5 a short operation finishing first must wait behind a long one
    wait_empty();
    out_ready = 1'b0;
    send(PAT_5, PAT_A, 1'b1);
    send('0, '0, 1'b0);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    #4;
    chk(!out_valid, "R5 later result held back", 64'(out_valid), 64'd0);
    repeat (30) @(negedge clk);
    #4;
    chk(out_valid && out_sum == '0 && out_cout, "R5 earlier result first",
        64'({out_valid, out_cout}), 64'b11);
    @(negedge clk); #1;
    out_ready = 1'b1;
    wait_empty();

    // R4 fill every unit with the consumer stalled
    out_ready = 1'b0;
    for (int k = 0; k < N; k++) send(rnd_w(), rnd_w(), 1'b0);
    ra = rnd_w(); rb = rnd_w();
    in_valid = 1'b1; in_a = ra; in_b = rb; in_cin = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #4;
      chk(!in_ready, "R4 stall when rotation full", 64'(in_ready), 64'd0);
    end
    @(negedge clk); #1;
    out_ready = 1'b1;
    send(ra, rb, 1'b1);
    in_valid = 1'b0;
    wait_empty();

    // R9 full-rate stream with concurrent accept and retire
    stalls = 0; both_cnt = 0;
    for (int k = 0; k < 40; k++) send(rnd_w() & PAT_5, rnd_w() & PAT_5, 1'($urandom_range(0, 1)));
    in_valid = 1'b0;
    chk(stalls == 0, "R9 no stall on short chains", 64'(stalls), 64'd0);
    chk(both_cnt > 0, "R9 accept and retire together", 64'(both_cnt), 64'd1);
    wait_empty();

    // random traffic with random back-pressure
    rnd_ready = 1'b1;
    for (int k = 0; k < 300; k++) begin
      ra = rnd_w();
      case ($urandom_range(0, 3))
        0:       rb = ~ra;
        1:       rb = rnd_w() & PAT_5;
        default: rb = rnd_w();
      endcase
      send(ra, rb, 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        @(negedge clk); #1;
      end
    end
    in_valid = 1'b0;
    rnd_ready = 1'b0;
    @(negedge clk); #1;
    out_ready = 1'b1;
    wait_empty();
    chk(exp_q.size() == 0, "R1 all results returned", 64'(exp_q.size()), 64'd0);

    // R8 incrementer variant
    inc_op({W{1'b1}}, rnd_w(), 1'b1);
    inc_op(W'(56'h3F), {W{1'b1}}, 1'b1);
    inc_op(rnd_w(), rnd_w(), 1'b0);
    inc_op(rnd_w(), rnd_w(), 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule